// File: doc/BRIEF.md
# Keccak Helper Vector ALU

This block is a single-issue execution unit for four 32-bit instruction words that speed up the Keccak permutation on a 128-bit datapath made of two independent 64-bit lanes. Each word names up to three source registers and one destination register. The unit sends the three source indices back to the register file in the same cycle the word is presented. The register file returns the three 128-bit operand values in that same cycle. One clock edge later the unit presents the result, the destination index and a write-enable.

The four operations are a three-input XOR, an XOR with a one-bit left rotation of the second operand, a bit-clear-then-XOR, and an XOR followed by a right rotation whose amount is encoded in the word. The rotations act inside each 64-bit lane. A presented word that fits none of the four encodings raises an illegal flag instead of a write-enable. The register file, fetch and any trap handling sit outside the block.

Top module: `kv_alu`

## Requirements
- R1: While reset is active, and until the first word is accepted after reset, `wb_en` and `illegal` are 0 and `wb_data` and `wb_idx` are all zeros.
- R2: A presented word whose bits other than [20:16], [14:10], [9:5] and [4:0] equal 32'hCE000000 produces, one edge later, `wb_en`=1 and `wb_data` = N ^ M ^ A over all 128 bits.
- R3: A presented word whose bits other than [20:16], [9:5] and [4:0] equal 32'hCE608C00 produces, one edge later, `wb_en`=1 and, in each 64-bit lane, N ^ (M rotated left by one bit within that lane).
- R4: A presented word whose bits other than [20:16], [14:10], [9:5] and [4:0] equal 32'hCE200000 produces, one edge later, `wb_en`=1 and `wb_data` = N ^ (M & ~A).
- R5: A presented word whose bits [31:21] equal the top bits of 32'hCE800000 produces, one edge later, `wb_en`=1 and, in each 64-bit lane, (N ^ M) rotated right within that lane by the unsigned amount in bits [15:10]. An amount of 0 gives N ^ M unchanged.
- R6: The source indices are driven combinationally from the presented word: `src_n_idx` from bits [9:5], `src_m_idx` from bits [20:16], and `src_a_idx` from bits [14:10].
- R7: After a legal word, `wb_idx` equals bits [4:0] of that word.
- R8: A presented word that matches none of the four encodings makes `illegal`=1 and `wb_en`=0 one edge later.
- R9: In a cycle with `issue_valid`=0 or an illegal word, the following edge leaves `wb_en`=0, and `wb_data` and `wb_idx` keep their previous values. With `issue_valid`=0, `illegal` is also 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| issue_valid | input | 1 | A word is presented this cycle |
| issue_word | input | 32 | Instruction word |
| src_n_idx | output | 5 | Index of the first source register |
| src_m_idx | output | 5 | Index of the second source register |
| src_a_idx | output | 5 | Index of the third source register |
| opnd_n | input | 128 | Value of the first source register |
| opnd_m | input | 128 | Value of the second source register |
| opnd_a | input | 128 | Value of the third source register |
| wb_en | output | 1 | Result is valid and must be written |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 128 | Result value |
| illegal | output | 1 | The previous presented word was not recognised |

## Verification
The two functions that meet in one cycle are retiring a legal result and rejecting an illegal word. In back-to-back issue, the output register shows the first result while the next word is being decoded. The bench issues a legal word and then, with no idle gap, an encoding that misses a fixed bit of one of the patterns. It then checks that the flag rises, that the write-enable drops, and that the data and index still hold the legal word's result. Rotations are judged with lane-boundary bit patterns so that any carry between the two lanes shows up in the result.

// File: rtl/kv_pkg.sv
package kv_pkg;

  localparam int WORD_W    = 32;
  localparam int IDX_W     = 5;
  localparam int ROT_W     = 6;
  localparam int N_ENC     = 4;

  // Fixed-bit masks: register and immediate fields cleared
  localparam logic [WORD_W-1:0] MASK_3SRC = 32'hFFE0_8000;
  localparam logic [WORD_W-1:0] MASK_2SRC = 32'hFFE0_FC00;
  localparam logic [WORD_W-1:0] MASK_IMM  = 32'hFFE0_0000;

  localparam logic [WORD_W-1:0] PAT_XOR3  = 32'hCE00_0000;
  localparam logic [WORD_W-1:0] PAT_BCLR  = 32'hCE20_0000;
  localparam logic [WORD_W-1:0] PAT_XROL  = 32'hCE60_8C00;
  localparam logic [WORD_W-1:0] PAT_XROR  = 32'hCE80_0000;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_XOR3  = 3'd1,
    OP_BCLR  = 3'd2,
    OP_XROL  = 3'd3,
    OP_XROR  = 3'd4
  } kv_op_e;

  function automatic logic [WORD_W-1:0] enc_mask(input int k);
    case (k)
      0, 1:    return MASK_3SRC;
      2:       return MASK_2SRC;
      default: return MASK_IMM;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] enc_pat(input int k);
    case (k)
      0:       return PAT_XOR3;
      1:       return PAT_BCLR;
      2:       return PAT_XROL;
      default: return PAT_XROR;
    endcase
  endfunction

endpackage

// File: rtl/kv_decode.sv
module kv_decode
  import kv_pkg::*;
(
  input  logic              valid,
  input  logic [WORD_W-1:0] word,
  output kv_op_e            op,
  output logic [IDX_W-1:0]  rd,
  output logic [IDX_W-1:0]  rn,
  output logic [IDX_W-1:0]  rm,
  output logic [IDX_W-1:0]  ra,
  output logic [ROT_W-1:0]  rot,
  output logic              legal,
  output logic              bad
);

  logic [N_ENC-1:0] hit;

  // One comparator per encoding
  for (genvar k = 0; k < N_ENC; k++) begin : g_match
    assign hit[k] = ((word & enc_mask(k)) == enc_pat(k));
  end

  always_comb begin
    op = OP_NONE;
    unique case (1'b1)
      hit[0]:  op = OP_XOR3;
      hit[1]:  op = OP_BCLR;
      hit[2]:  op = OP_XROL;
      hit[3]:  op = OP_XROR;
      default: op = OP_NONE;
    endcase
  end

  assign rd    = word[4:0];
  assign rn    = word[9:5];
  assign ra    = word[14:10];
  assign rm    = word[20:16];
  assign rot   = word[15:10];
  assign legal = valid && (hit != '0);
  assign bad   = valid && (hit == '0);

endmodule

// File: rtl/kv_lane.sv
module kv_lane
  import kv_pkg::*;
#(
  parameter int LANE_W = 64
) (
  input  kv_op_e            op,
  input  logic [LANE_W-1:0] n,
  input  logic [LANE_W-1:0] m,
  input  logic [LANE_W-1:0] a,
  input  logic [ROT_W-1:0]  rot,
  output logic [LANE_W-1:0] y
);

  localparam int DBL_W = 2 * LANE_W;

  logic [LANE_W-1:0] mix;
  logic [DBL_W-1:0]  dbl;
  logic [LANE_W-1:0] m_rol1;

  assign mix    = n ^ m;
  assign dbl    = {mix, mix} >> rot;
  assign m_rol1 = {m[LANE_W-2:0], m[LANE_W-1]};

  always_comb begin
    case (op)
      OP_XOR3: y = mix ^ a;
      OP_BCLR: y = n ^ (m & ~a);
      OP_XROL: y = n ^ m_rol1;
      OP_XROR: y = dbl[LANE_W-1:0];
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/kv_alu.sv
module kv_alu
  import kv_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int LANE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [31:0]       issue_word,
  output logic [4:0]        src_n_idx,
  output logic [4:0]        src_m_idx,
  output logic [4:0]        src_a_idx,
  input  logic [DATA_W-1:0] opnd_n,
  input  logic [DATA_W-1:0] opnd_m,
  input  logic [DATA_W-1:0] opnd_a,
  output logic              wb_en,
  output logic [4:0]        wb_idx,
  output logic [DATA_W-1:0] wb_data,
  output logic              illegal
);

  localparam int N_LANES = DATA_W / LANE_W;

  // Reset synchronizer: assert async, release on clock
  logic [1:0] rst_q;
  logic       rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_sync = rst_q[1];

  // Decode
  kv_op_e           dec_op;
  logic [IDX_W-1:0] dec_rd;
  logic [ROT_W-1:0] dec_rot;
  logic             dec_legal;
  logic             dec_bad;

  kv_decode u_dec (
    .valid (issue_valid),
    .word  (issue_word),
    .op    (dec_op),
    .rd    (dec_rd),
    .rn    (src_n_idx),
    .rm    (src_m_idx),
    .ra    (src_a_idx),
    .rot   (dec_rot),
    .legal (dec_legal),
    .bad   (dec_bad)
  );

  // Lane datapath
  logic [DATA_W-1:0] lane_res;

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    kv_lane #(.LANE_W(LANE_W)) u_lane (
      .op  (dec_op),
      .n   (opnd_n[i*LANE_W +: LANE_W]),
      .m   (opnd_m[i*LANE_W +: LANE_W]),
      .a   (opnd_a[i*LANE_W +: LANE_W]),
      .rot (dec_rot),
      .y   (lane_res[i*LANE_W +: LANE_W])
    );
  end

  // Next state
  logic              en_d, bad_d;
  logic [DATA_W-1:0] data_d;
  logic [IDX_W-1:0]  idx_d;
  logic              load_en;

  always_comb begin
    load_en = dec_legal;
    en_d    = dec_legal;
    bad_d   = dec_bad;
    data_d  = wb_data;
    idx_d   = wb_idx;
    if (load_en) begin
      data_d = lane_res;
      idx_d  = dec_rd;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      wb_en   <= 1'b0;
      illegal <= 1'b0;
      wb_data <= '0;
      wb_idx  <= '0;
    end else begin
      wb_en   <= en_d;
      illegal <= bad_d;
      wb_data <= data_d;
      wb_idx  <= idx_d;
    end
  end

endmodule

// File: rtl/kv_alu_chk.sv
module kv_alu_chk
  import kv_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue_valid,
  input logic [31:0]       issue_word,
  input logic [DATA_W-1:0] opnd_n,
  input logic [DATA_W-1:0] opnd_m,
  input logic [DATA_W-1:0] opnd_a,
  input logic              wb_en,
  input logic [4:0]        wb_idx,
  input logic [DATA_W-1:0] wb_data,
  input logic              illegal
);

  logic is_xor3, is_bclr, is_xrol, is_xror, is_any;
  assign is_xor3 = (issue_word & MASK_3SRC) == PAT_XOR3;
  assign is_bclr = (issue_word & MASK_3SRC) == PAT_BCLR;
  assign is_xrol = (issue_word & MASK_2SRC) == PAT_XROL;
  assign is_xror = (issue_word & MASK_IMM)  == PAT_XROR;
  assign is_any  = is_xor3 | is_bclr | is_xrol | is_xror;

  p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wb_en, illegal}));

  p_xor3_r2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && is_xor3 |=> wb_en && wb_data == $past(opnd_n ^ opnd_m ^ opnd_a));

  p_bclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && is_bclr |=> wb_en && wb_data == $past(opnd_n ^ (opnd_m & ~opnd_a)));

  p_dest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && is_any |=> wb_idx == $past(issue_word[4:0]));

  p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && !is_any |=> illegal && !wb_en);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> !wb_en && !illegal);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_valid && is_any) |=> $stable(wb_data) && $stable(wb_idx));

endmodule

bind kv_alu kv_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .issue_valid (issue_valid),
  .issue_word  (issue_word),
  .opnd_n      (opnd_n),
  .opnd_m      (opnd_m),
  .opnd_a      (opnd_a),
  .wb_en       (wb_en),
  .wb_idx      (wb_idx),
  .wb_data     (wb_data),
  .illegal     (illegal)
);

// File: tb/kv_alu_bench.sv
`timescale 1ns/1ps
module kv_alu_bench;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         issue_valid;
  logic [31:0]  issue_word;
  logic [4:0]   src_n_idx, src_m_idx, src_a_idx;
  logic [127:0] opnd_n, opnd_m, opnd_a;
  logic         wb_en;
  logic [4:0]   wb_idx;
  logic [127:0] wb_data;
  logic         illegal;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  kv_alu u_kv_alu (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_word(issue_word),
    .src_n_idx(src_n_idx), .src_m_idx(src_m_idx), .src_a_idx(src_a_idx),
    .opnd_n(opnd_n), .opnd_m(opnd_m), .opnd_a(opnd_a),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .illegal(illegal)
  );

  localparam logic [31:0] B_XOR3 = 32'hCE00_0000;
  localparam logic [31:0] B_BCLR = 32'hCE20_0000;
  localparam logic [31:0] B_XROL = 32'hCE60_8C00;
  localparam logic [31:0] B_XROR = 32'hCE80_0000;

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] w3(input logic [31:0] b, input int rd,
                                     input int rn, input int rm, input int ra);
    return b | 32'(rd) | (32'(rn) << 5) | (32'(ra) << 10) | (32'(rm) << 16);
  endfunction

  function automatic logic [31:0] wi(input int rd, input int rn, input int rm, input int imm);
    return B_XROR | 32'(rd) | (32'(rn) << 5) | (32'(imm) << 10) | (32'(rm) << 16);
  endfunction

  function automatic logic [127:0] m_rol1(input logic [127:0] x);
    logic [127:0] r;
    for (int i = 0; i < 2; i++) r[i*64 +: 64] = {x[i*64 +: 63], x[i*64 + 63]};
    return r;
  endfunction

  function automatic logic [127:0] m_ror(input logic [127:0] x, input int s);
    logic [127:0] r;
    for (int i = 0; i < 2; i++) begin
      logic [63:0] v;
      v = x[i*64 +: 64];
      r[i*64 +: 64] = (s == 0) ? v : ((v >> s) | (v << (64 - s)));
    end
    return r;
  endfunction

  // Present a word at the falling edge; check source indices (R6)
  task automatic present(input logic [31:0] w, input logic [127:0] n,
                         input logic [127:0] m, input logic [127:0] a);
    @(negedge clk);
    issue_valid = 1'b1;
    issue_word  = w;
    opnd_n = n; opnd_m = m; opnd_a = a;
    #1;
    chk("R6", "src_n_idx", 128'(src_n_idx), 128'(w[9:5]));
    chk("R6", "src_m_idx", 128'(src_m_idx), 128'(w[20:16]));
    chk("R6", "src_a_idx", 128'(src_a_idx), 128'(w[14:10]));
  endtask

  task automatic settle();
    @(posedge clk);
    #1;
  endtask

  task automatic go_idle();
    @(negedge clk);
    issue_valid = 1'b0;
    issue_word  = 32'h0;
  endtask

  task automatic t_reset();
    chk("R1", "wb_en", 128'(wb_en), 128'(0));
    chk("R1", "illegal", 128'(illegal), 128'(0));
    chk("R1", "wb_data", wb_data, 128'(0));
    chk("R1", "wb_idx", 128'(wb_idx), 128'(0));
  endtask

  task automatic t_xor3();
    logic [127:0] n, m, a;
    n = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    m = 128'hFFFF_0000_FFFF_0000_0F0F_0F0F_F0F0_F0F0;
    a = 128'hAAAA_5555_1234_8765_0000_FFFF_DEAD_BEEF;
    present(w3(B_XOR3, 7, 3, 12, 25), n, m, a);
    settle();
    chk("R2", "xor3 wb_en", 128'(wb_en), 128'(1));
    chk("R2", "xor3 data", wb_data, n ^ m ^ a);
    chk("R7", "xor3 dest", 128'(wb_idx), 128'(7));
    present(w3(B_XOR3, 31, 31, 31, 31), ~n, n, m);
    settle();
    chk("R2", "xor3 all-ones fields data", wb_data, ~n ^ n ^ m);
    chk("R7", "xor3 dest 31", 128'(wb_idx), 128'(31));
    go_idle();
  endtask

  task automatic t_bclr();
    logic [127:0] n, m, a;
    n = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
    m = 128'hFFFF_FFFF_0000_0000_FFFF_0000_FFFF_0000;
    a = 128'h00FF_00FF_00FF_00FF_0F0F_0F0F_0F0F_0F0F;
    present(w3(B_BCLR, 4, 1, 2, 3), n, m, a);
    settle();
    chk("R4", "bclr wb_en", 128'(wb_en), 128'(1));
    chk("R4", "bclr data", wb_data, n ^ (m & ~a));
    chk("R7", "bclr dest", 128'(wb_idx), 128'(4));
    go_idle();
  endtask

  task automatic t_xrol();
    logic [127:0] n, m;
    n = 128'h0000_0000_0000_0000_FFFF_FFFF_FFFF_FFFF;
    m = 128'h8000_0000_0000_0001_8000_0000_0000_0000;
    present(w3(B_XROL, 9, 5, 6, 0), n, m, 128'h0);
    settle();
    chk("R3", "xrol wb_en", 128'(wb_en), 128'(1));
    chk("R3", "xrol lane wrap", wb_data, n ^ m_rol1(m));
    chk("R3", "xrol literal", wb_data,
        128'h0000_0000_0000_0003_FFFF_FFFF_FFFF_FFFE);
    go_idle();
  endtask

  task automatic t_xror();
    logic [127:0] n, m;
    int amt [4] = '{0, 1, 63, 36};
    n = 128'h0000_0000_0000_0001_8000_0000_0000_0000;
    m = 128'h0123_4567_89AB_CDEF_0000_0000_0000_0000;
    foreach (amt[k]) begin
      present(wi(k + 1, 2, 3, amt[k]), n, m, 128'h0);
      settle();
      chk("R5", $sformatf("xror rot %0d", amt[k]), wb_data, m_ror(n ^ m, amt[k]));
      chk("R5", "xror wb_en", 128'(wb_en), 128'(1));
    end
    go_idle();
  endtask

  task automatic t_illegal_and_idle();
    logic [127:0] held;
    present(w3(B_XOR3, 13, 1, 1, 1), 128'h5, 128'h6, 128'h9);
    settle();
    held = wb_data;
    chk("R2", "pre-illegal data", held, 128'h5 ^ 128'h6 ^ 128'h9);
    // Rotate-by-one pattern with bit 10 cleared: matches no encoding
    present(32'hCE60_8800 | 32'd21, 128'h1, 128'h2, 128'h3);
    settle();
    chk("R8", "illegal flag", 128'(illegal), 128'(1));
    chk("R8", "wb_en low", 128'(wb_en), 128'(0));
    chk("R9", "data held on illegal", wb_data, held);
    chk("R9", "idx held on illegal", 128'(wb_idx), 128'(13));
    present(32'hCE40_0000, 128'h1, 128'h2, 128'h3);
    settle();
    chk("R8", "second illegal flag", 128'(illegal), 128'(1));
    go_idle();
    opnd_n = '1; opnd_m = 128'h77; opnd_a = 128'h33;
    settle();
    chk("R9", "idle wb_en", 128'(wb_en), 128'(0));
    chk("R9", "idle illegal", 128'(illegal), 128'(0));
    chk("R9", "idle data held", wb_data, held);
    chk("R9", "idle idx held", 128'(wb_idx), 128'(13));
  endtask

  // Legal result retiring while the next, illegal word is decoded
  task automatic t_back_to_back();
    logic [127:0] n, m, a, exp;
    n = 128'hCAFE_0000_0000_BEEF_0000_1111_2222_3333;
    m = 128'h0000_FFFF_FFFF_0000_4444_5555_6666_7777;
    a = 128'h1234_1234_1234_1234_8888_9999_AAAA_BBBB;
    exp = n ^ (m & ~a);
    present(w3(B_BCLR, 18, 4, 8, 16), n, m, a);
    settle();
    chk("R4", "b2b first wb_en", 128'(wb_en), 128'(1));
    present(32'hCE20_8000, a, m, n);
    settle();
    chk("R8", "b2b illegal", 128'(illegal), 128'(1));
    chk("R8", "b2b wb_en", 128'(wb_en), 128'(0));
    chk("R9", "b2b data held", wb_data, exp);
    chk("R7", "b2b idx held", 128'(wb_idx), 128'(18));
    go_idle();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    issue_valid = 1'b0;
    issue_word  = 32'h0;
    opnd_n = '0; opnd_m = '0; opnd_a = '0;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_xor3();
    t_bclr();
    t_xrol();
    t_xror();
    t_illegal_and_idle();
    t_back_to_back();
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule